// File: doc/BRIEF.md
# Indexed DDC Byte Buffer

This block is the byte store that sits between a register-mapped host port and an I2C/DDC transaction engine. The host reaches it through one 32-bit data word. Each host write carries a data byte, a direction bit, an index value and an index-load flag. In write direction the byte is stored at an auto-incrementing pointer. In read direction with the load flag set, only the pointer is set up. Host reads then stream buffered bytes out through a one-deep prefetch stage. Because of that stage, the first read after such a pointer load returns a stale byte that software throws away.

The engine side has its own write and read ports, addressed by pointers the engine supplies. Through them it picks up the outgoing bytes that software staged and deposits received bytes. A typical use runs like this. The host writes a slave address byte (address shifted left one place, direction in the LSB) at index 0, and for a write transaction follows it with payload bytes. For a read transaction the engine fills the positions just after that address byte, and the next transaction's address byte follows them. Afterwards the host loads the index of the first received byte in read direction, discards one read, and reads the bytes in order.

A small state machine tracks the host access phase. Its states are PS_WRITE (after reset, a soft reset or any write-direction store), PS_PRIME (pointer just loaded in read direction, prefetch stale) and PS_STREAM (prefetch stage primed). Its transitions are:
- write store: any state to PS_WRITE
- read-direction index load: any state to PS_PRIME
- first host read: PS_PRIME to PS_STREAM
- soft reset: any state to PS_WRITE

Top module: `ddc_index_buffer`

## Requirements
- R1: After `rst_n` is released, the pointer is 0 and both `host_rdata` and `eng_rdata` read 0x00.
- R2: The host word layout is fixed: data byte in bits [7:0], direction in bit 8 (1 = read, 0 = write), index in bits [23:16] (only the low log2(DEPTH) bits are used), index-load flag in bit 31.
- R3: A host write with the index-load flag set loads the pointer from the index field before the access; in write direction the byte lands at that index.
- R4: A write-direction host write stores the byte at the pointer and then advances the pointer by one, so successive writes fill consecutive positions.
- R5: After a read-direction index load, the first host read returns the byte held in the prefetch stage before the load (to be discarded); each later read returns the next buffered byte, starting at the loaded index. `host_rdata` updates on the clock edge that samples `host_re`.
- R6: Host reads advance the pointer by one, and the pointer wraps from DEPTH-1 to 0 for both reads and writes.
- R7: An engine write stores `eng_wdata` at `eng_waddr`; an engine read presents the byte at `eng_raddr` on `eng_rdata` after the sampling edge, and `eng_rdata` holds otherwise.
- R8: When `eng_we` and `host_we` are both high, the host write has no effect: no byte is stored and the pointer does not move.
- R9: When `eng_re` and `host_re` are both high, the host read is dropped: `host_rdata` and the pointer are unchanged.
- R10: `soft_rst` sets the pointer to 0 and the state to PS_WRITE, ignores any host access in that cycle, and leaves the stored bytes intact.
- R11: A read-direction host write without the index-load flag has no effect. A host read in a cycle with `host_we` high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous pointer reset |
| host_we | input | 1 | Host data word write strobe |
| host_wword | input | 32 | Host data word (fields per R2) |
| host_re | input | 1 | Host data read strobe |
| host_rdata | output | 8 | Byte returned by the last host read |
| eng_we | input | 1 | Engine write strobe |
| eng_waddr | input | IDX_W | Engine write position |
| eng_wdata | input | 8 | Engine write byte |
| eng_re | input | 1 | Engine read strobe |
| eng_raddr | input | IDX_W | Engine read position |
| eng_rdata | output | 8 | Byte from the last engine read |

## Verification
Directed sequences cover the following cases:
- a full-depth sequential fill and readback, which separates correct pointer wrap from a clamp or an off-by-one;
- a DDC-style read transaction, in which the host stages an address byte, the engine deposits bytes after it, and the host reads them back, which shows whether the discard byte sits exactly once in front of the data;
- same-cycle collisions of host and engine accesses, and a soft reset, which check that the losing access leaves no trace in contents or pointer.

Constrained random traffic then mixes loads, stores, reads, engine accesses and rare soft resets. Its results are compared against a bench model built from the requirements, which exposes ordering faults that the directed cases miss.

// File: rtl/ddc_buf_pkg.sv
package ddc_buf_pkg;

    localparam int HOST_WORD_W = 32;
    localparam int DATA_LSB    = 0;
    localparam int DIR_BIT     = 8;
    localparam int INDEX_LSB   = 16;
    localparam int INDEX_FW    = 8;
    localparam int LOAD_BIT    = 31;

    typedef enum logic [1:0] {
        PS_WRITE  = 2'd0,
        PS_PRIME  = 2'd1,
        PS_STREAM = 2'd2
    } ptr_state_e;

    typedef struct packed {
        logic                load;
        logic [INDEX_FW-1:0] index;
        logic                rd_dir;
        logic [7:0]          data;
    } host_cmd_t;

    function automatic host_cmd_t unpack_word(input logic [HOST_WORD_W-1:0] w);
        host_cmd_t c;
        c.load   = w[LOAD_BIT];
        c.index  = w[INDEX_LSB +: INDEX_FW];
        c.rd_dir = w[DIR_BIT];
        c.data   = w[DATA_LSB +: 8];
        return c;
    endfunction

endpackage

// File: rtl/ddc_host_decode.sv
module ddc_host_decode
    import ddc_buf_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [HOST_WORD_W-1:0] host_wword,
    input  logic                   host_we,
    input  logic                   host_re,
    input  logic                   eng_we,
    input  logic                   eng_re,
    input  logic                   soft_rst,
    output logic                   hw_ok,
    output logic                   hr_ok,
    output logic                   cmd_load,
    output logic                   cmd_rd_dir,
    output logic [IDX_W-1:0]       cmd_index,
    output logic [7:0]             cmd_data
);

    host_cmd_t cmd;

    always_comb begin
        cmd        = unpack_word(host_wword);
        cmd_load   = cmd.load;
        cmd_rd_dir = cmd.rd_dir;
        cmd_index  = cmd.index[IDX_W-1:0];
        cmd_data   = cmd.data;
        // engine owns the write port; soft reset drops host traffic
        hw_ok      = host_we && !eng_we && !soft_rst;
        // engine owns the read port; a host write masks the read
        hr_ok      = host_re && !host_we && !eng_re && !soft_rst;
    end

endmodule

// File: rtl/ddc_ptr_ctrl.sv
module ddc_ptr_ctrl
    import ddc_buf_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             hw_ok,
    input  logic             hr_ok,
    input  logic             cmd_load,
    input  logic             cmd_rd_dir,
    input  logic [IDX_W-1:0] cmd_index,
    output logic [IDX_W-1:0] ptr_q,
    output logic [IDX_W-1:0] store_addr,
    output logic             store_en,
    output ptr_state_e       state_q
);

    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    ptr_state_e       state_d;
    logic [IDX_W-1:0] ptr_d;
    logic [IDX_W-1:0] base;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_WRITE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = PS_WRITE;
        end else begin
            unique case (state_q)
                PS_WRITE, PS_STREAM: begin
                    if (hw_ok && !cmd_rd_dir)            state_d = PS_WRITE;
                    else if (hw_ok && cmd_load)          state_d = PS_PRIME;
                end
                PS_PRIME: begin
                    if (hw_ok && !cmd_rd_dir)            state_d = PS_WRITE;
                    else if (hw_ok && cmd_load)          state_d = PS_PRIME;
                    else if (hr_ok)                      state_d = PS_STREAM;
                end
                default:                                 state_d = PS_WRITE;
            endcase
        end
    end

    // pointer and store outputs
    always_comb begin
        base       = cmd_load ? cmd_index : ptr_q;
        store_en   = hw_ok && !cmd_rd_dir;
        store_addr = base;
        ptr_d      = ptr_q;
        if (soft_rst) begin
            ptr_d = '0;
        end else if (hw_ok) begin
            if (!cmd_rd_dir)   ptr_d = base + ONE;
            else if (cmd_load) ptr_d = cmd_index;
        end else if (hr_ok) begin
            ptr_d = ptr_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

endmodule

// File: rtl/ddc_byte_ram.sv
module ddc_byte_ram #(
    parameter int DEPTH = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_waddr,
    input  logic [7:0]       eng_wdata,
    input  logic             host_st,
    input  logic [IDX_W-1:0] host_waddr,
    input  logic [7:0]       host_wdata,
    input  logic             host_go,
    input  logic [IDX_W-1:0] host_raddr,
    output logic [7:0]       host_rdata,
    input  logic             eng_re,
    input  logic [IDX_W-1:0] eng_raddr,
    output logic [7:0]       eng_rdata
);

    logic [7:0]       mem_q [DEPTH];
    logic             wr_en;
    logic [IDX_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic [7:0]       pf_q;
    logic [7:0]       rd_q;
    logic [7:0]       erd_q;

    // single write port, engine first
    always_comb begin
        wr_en   = eng_we || host_st;
        wr_addr = eng_we ? eng_waddr : host_waddr;
        wr_data = eng_we ? eng_wdata : host_wdata;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    // host read path: prefetch stage in front of the returned byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_q <= '0;
            rd_q <= '0;
        end else if (host_go) begin
            rd_q <= pf_q;
            pf_q <= mem_q[host_raddr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            erd_q <= '0;
        end else if (eng_re) begin
            erd_q <= mem_q[eng_raddr];
        end
    end

    assign host_rdata = rd_q;
    assign eng_rdata  = erd_q;

endmodule

// File: rtl/ddc_index_buffer.sv
module ddc_index_buffer
    import ddc_buf_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   soft_rst,
    input  logic                   host_we,
    input  logic [HOST_WORD_W-1:0] host_wword,
    input  logic                   host_re,
    output logic [7:0]             host_rdata,
    input  logic                   eng_we,
    input  logic [IDX_W-1:0]       eng_waddr,
    input  logic [7:0]             eng_wdata,
    input  logic                   eng_re,
    input  logic [IDX_W-1:0]       eng_raddr,
    output logic [7:0]             eng_rdata
);

    logic             hw_ok;
    logic             hr_ok;
    logic             cmd_load;
    logic             cmd_rd_dir;
    logic [IDX_W-1:0] cmd_index;
    logic [7:0]       cmd_data;
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] store_addr;
    logic             store_en;
    ptr_state_e       state_q;

    ddc_host_decode #(.IDX_W(IDX_W)) u_dec (
        .host_wword (host_wword),
        .host_we    (host_we),
        .host_re    (host_re),
        .eng_we     (eng_we),
        .eng_re     (eng_re),
        .soft_rst   (soft_rst),
        .hw_ok      (hw_ok),
        .hr_ok      (hr_ok),
        .cmd_load   (cmd_load),
        .cmd_rd_dir (cmd_rd_dir),
        .cmd_index  (cmd_index),
        .cmd_data   (cmd_data)
    );

    ddc_ptr_ctrl #(.IDX_W(IDX_W)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .hw_ok      (hw_ok),
        .hr_ok      (hr_ok),
        .cmd_load   (cmd_load),
        .cmd_rd_dir (cmd_rd_dir),
        .cmd_index  (cmd_index),
        .ptr_q      (ptr_q),
        .store_addr (store_addr),
        .store_en   (store_en),
        .state_q    (state_q)
    );

    ddc_byte_ram #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .eng_we     (eng_we),
        .eng_waddr  (eng_waddr),
        .eng_wdata  (eng_wdata),
        .host_st    (store_en),
        .host_waddr (store_addr),
        .host_wdata (cmd_data),
        .host_go    (hr_ok),
        .host_raddr (ptr_q),
        .host_rdata (host_rdata),
        .eng_re     (eng_re),
        .eng_raddr  (eng_raddr),
        .eng_rdata  (eng_rdata)
    );

endmodule

// File: rtl/ddc_index_buffer_chk.sv
module ddc_index_buffer_chk
    import ddc_buf_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   soft_rst,
    input logic                   host_we,
    input logic [HOST_WORD_W-1:0] host_wword,
    input logic                   host_re,
    input logic [7:0]             host_rdata,
    input logic                   eng_we,
    input logic                   eng_re,
    input logic [IDX_W-1:0]       ptr_q,
    input ptr_state_e             state_q
);

    AST_LOAD_READ_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && !eng_we && !soft_rst && host_wword[LOAD_BIT] && host_wword[DIR_BIT]
        |=> ptr_q == $past(host_wword[INDEX_LSB +: IDX_W])); // R3

    AST_STORE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && !eng_we && !soft_rst && !host_wword[LOAD_BIT] && !host_wword[DIR_BIT]
        |=> ptr_q == IDX_W'($past(ptr_q) + IDX_W'(1))); // R4

    AST_PRIME_TO_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PS_PRIME && host_re && !host_we && !eng_re && !soft_rst
        |=> state_q == PS_STREAM); // R5

    AST_ENG_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_we && host_we && !soft_rst |=> $stable(ptr_q)); // R8

    AST_ENG_RD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_re && !host_we && !soft_rst |=> $stable(ptr_q) && $stable(host_rdata)); // R9

    AST_SOFT_CLEARS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ptr_q == '0 && state_q == PS_WRITE); // R10

    AST_BARE_READ_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && !soft_rst && host_wword[DIR_BIT] && !host_wword[LOAD_BIT]
        |=> $stable(ptr_q) && $stable(host_rdata)); // R11

endmodule

bind ddc_index_buffer ddc_index_buffer_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .host_we    (host_we),
    .host_wword (host_wword),
    .host_re    (host_re),
    .host_rdata (host_rdata),
    .eng_we     (eng_we),
    .eng_re     (eng_re),
    .ptr_q      (ptr_q),
    .state_q    (state_q)
);

// File: tb/ddc_index_buffer_tb.sv
module ddc_index_buffer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;
    localparam int IW         = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          soft_rst = 1'b0;
    logic          host_we = 1'b0;
    logic [31:0]   host_wword = '0;
    logic          host_re = 1'b0;
    logic [7:0]    host_rdata;
    logic          eng_we = 1'b0;
    logic [IW-1:0] eng_waddr = '0;
    logic [7:0]    eng_wdata = '0;
    logic          eng_re = 1'b0;
    logic [IW-1:0] eng_raddr = '0;
    logic [7:0]    eng_rdata;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    logic [7:0]    m_mem [DEPTH];
    logic [IW-1:0] m_ptr;
    logic [7:0]    m_pf;
    logic [7:0]    m_rd;
    logic [7:0]    m_erd;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddc_index_buffer #(.DEPTH(DEPTH)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .host_we    (host_we),
        .host_wword (host_wword),
        .host_re    (host_re),
        .host_rdata (host_rdata),
        .eng_we     (eng_we),
        .eng_waddr  (eng_waddr),
        .eng_wdata  (eng_wdata),
        .eng_re     (eng_re),
        .eng_raddr  (eng_raddr),
        .eng_rdata  (eng_rdata)
    );

    // R2 word layout: data [7:0], dir bit 8 (1=read), index [23:16], load bit 31
    function automatic logic [31:0] mkw(input bit ld, input int idx, input bit rd, input int d);
        logic [31:0] w;
        w        = '0;
        w[31]    = ld;
        w[23:16] = 8'(idx);
        w[8]     = rd;
        w[7:0]   = 8'(d);
        return w;
    endfunction

    task automatic cmp(input logic [7:0] act, input logic [7:0] exp, input string tag);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, advance the model, compare at the next negedge
    task automatic step(input bit hwe, input logic [31:0] hw, input bit hre,
                        input bit ewe, input int ewa, input int ewd,
                        input bit ere, input int era, input bit srst, input string tag);
        bit            hw_ok, hr_ok;
        logic [IW-1:0] base;
        host_we = hwe; host_wword = hw; host_re = hre;
        eng_we = ewe; eng_waddr = IW'(ewa); eng_wdata = 8'(ewd);
        eng_re = ere; eng_raddr = IW'(era); soft_rst = srst;
        hw_ok = hwe && !ewe && !srst;
        hr_ok = hre && !hwe && !ere && !srst;
        if (ere) m_erd = m_mem[IW'(era)];
        if (hr_ok) begin
            m_rd  = m_pf;
            m_pf  = m_mem[m_ptr];
            m_ptr = m_ptr + 1'b1;
        end
        if (srst) begin
            m_ptr = '0;
        end else if (hw_ok) begin
            base = hw[31] ? hw[16 +: IW] : m_ptr;
            if (!hw[8]) begin
                m_mem[base] = hw[7:0];
                m_ptr = base + 1'b1;
            end else if (hw[31]) begin
                m_ptr = hw[16 +: IW];
            end
        end
        if (ewe) m_mem[IW'(ewa)] = 8'(ewd);
        @(negedge clk);
        host_we = 1'b0; host_re = 1'b0; eng_we = 1'b0; eng_re = 1'b0; soft_rst = 1'b0;
        cmp(host_rdata, m_rd, {tag, " host_rdata"});
        cmp(eng_rdata, m_erd, {tag, " eng_rdata"});
    endtask

    task automatic hwr(input bit ld, input int idx, input int d, input string tag);
        step(1, mkw(ld, idx, 0, d), 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic hload_rd(input int idx, input string tag);
        step(1, mkw(1, idx, 1, 0), 0, 0, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic hrd(input string tag);
        step(0, '0, 1, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        m_ptr = '0; m_pf = '0; m_rd = '0; m_erd = '0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        cmp(host_rdata, 8'h00, "R1 host_rdata after reset");
        cmp(eng_rdata, 8'h00, "R1 eng_rdata after reset");

        // R4/R6: fill every position without loading, pointer starts at 0 and wraps
        for (int i = 0; i < DEPTH; i++) hwr(0, 0, 8'h40 + i, "R4 sequential store");
        hwr(0, 0, 8'hEE, "R6 write wrap to 0");
        // R5: read-direction load, discard byte, then in-order bytes
        hload_rd(0, "R3 read load");
        hrd("R5 discard byte");
        cmp(host_rdata, 8'h00, "R5 discard equals old prefetch");
        hrd("R5 first data");
        cmp(host_rdata, 8'hEE, "R5 byte at index 0");
        for (int i = 1; i < DEPTH; i++) hrd("R6 streaming read");
        hrd("R6 read wrap");
        cmp(host_rdata, 8'hEE, "R6 read pointer wrapped");

        // R3: load index in write direction stores at the index
        hwr(1, 7, 8'h5A, "R3 indexed store");
        hwr(0, 0, 8'h5B, "R4 follow-on store");
        hload_rd(7, "R3 read load");
        hrd("R5 discard");
        hrd("R3 read indexed"); cmp(host_rdata, 8'h5A, "R3 byte at index 7");
        hrd("R4 read next");    cmp(host_rdata, 8'h5B, "R4 byte at index 8");

        // DDC-style read transaction: address byte, engine deposits after it
        hwr(1, 0, (8'h50 << 1) | 1, "R2 address byte");
        step(0, '0, 0, 1, 1, 8'hC1, 0, 0, 0, "R7 engine deposit");
        step(0, '0, 0, 1, 2, 8'hC2, 0, 0, 0, "R7 engine deposit");
        step(0, '0, 0, 1, 3, 8'hC3, 1, 0, 0, "R7 engine read addr byte");
        cmp(eng_rdata, 8'hA1, "R7 engine sees address byte");
        hload_rd(1, "R5 load received");
        hrd("R5 discard");
        hrd("R5 rx0"); cmp(host_rdata, 8'hC1, "R5 received byte 0");
        hrd("R5 rx1"); cmp(host_rdata, 8'hC2, "R5 received byte 1");
        hrd("R5 rx2"); cmp(host_rdata, 8'hC3, "R5 received byte 2");

        // R8: engine write collides with host write
        hwr(1, 10, 8'h11, "R8 setup");
        step(1, mkw(0, 0, 0, 8'h99), 0, 1, 20, 8'h77, 0, 0, 0, "R8 collision");
        hwr(0, 0, 8'h12, "R8 after collision");
        step(0, '0, 0, 0, 0, 0, 1, 11, 0, "R8 probe");
        cmp(eng_rdata, 8'h12, "R8 host write dropped, pointer held");
        step(0, '0, 0, 0, 0, 0, 1, 20, 0, "R8 probe engine");
        cmp(eng_rdata, 8'h77, "R8 engine byte stored");

        // R9: engine read collides with host read
        hload_rd(10, "R9 setup"); hrd("R9 discard"); hrd("R9 first");
        cmp(host_rdata, 8'h11, "R9 setup byte");
        step(0, '0, 1, 0, 0, 0, 1, 3, 0, "R9 collision");
        cmp(host_rdata, 8'h11, "R9 host read dropped");
        hrd("R9 next"); cmp(host_rdata, 8'h12, "R9 pointer held");

        // R11: bare read-direction word and read masked by write
        step(1, mkw(0, 25, 1, 8'h33), 0, 0, 0, 0, 0, 0, 0, "R11 bare read word");
        hrd("R11 after bare word");
        step(1, mkw(1, 30, 0, 8'h44), 1, 0, 0, 0, 0, 0, 0, "R11 read under write");

        // R10: soft reset clears pointer, keeps contents
        step(1, mkw(1, 5, 0, 8'h66), 0, 0, 0, 0, 0, 0, 1, "R10 soft reset drops host");
        hwr(0, 0, 8'h88, "R10 store at 0");
        step(0, '0, 0, 0, 0, 0, 1, 0, 0, "R10 probe 0");
        cmp(eng_rdata, 8'h88, "R10 pointer was zero");
        step(0, '0, 0, 0, 0, 0, 1, 7, 0, "R10 probe 7");
        cmp(eng_rdata, 8'h5A, "R10 contents kept");

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            step(r < 40, mkw($urandom_range(0, 3) == 0, $urandom_range(0, 255),
                             $urandom_range(0, 3) == 0, $urandom_range(0, 255)),
                 r >= 30 && r < 80,
                 $urandom_range(0, 5) == 0, $urandom_range(0, DEPTH-1), $urandom_range(0, 255),
                 $urandom_range(0, 5) == 0, $urandom_range(0, DEPTH-1),
                 $urandom_range(0, 199) == 0, "R6 R7 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule